// File: doc/BRIEF.md
# Eight-Input Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output toward a processor. Software sets it up through a small register port that has a chip select, read and write strobes, one address bit and an 8-bit data bus. A fixed sequence of setup words arms the device. After that, a mask word chooses which inputs may interrupt.

A rising edge on an unmasked input, held high, raises the interrupt output. The processor answers with two acknowledge pulses. The first pulse moves the winning input from the pending set to the in-service set. During the second pulse the block drives an 8-bit vector on the data bus. The upper five bits of the vector come from the second setup word and the lower three bits hold the index of the input. Input 0 has the highest priority. In-service bits are cleared either at the end of the second pulse (automatic mode) or by an end-of-interrupt command write.

The port uses plain strobes. Every access completes in the cycle it is seen, so the port has no valid/ready handshake and no back-pressure. A write is taken once, on the first cycle in which chip select and write strobe are both low.

Top module: `pic8`

## Requirements
- R1: A write with `a0`=0 and data bit 4 = 1 is setup word one. It clears the mask, the pending set and the in-service set, and it clears automatic mode. Bit 1 = 1 means a single device and skips word three. Bit 0 = 1 means word four follows. The next `a0`=1 writes are taken as word two, then word three if not skipped, then word four if requested. Until this sequence completes, input edges are ignored and `int_out` stays low.
- R2: After setup, a write with `a0`=1 loads the mask. Bit n = 1 masks input n, and a masked input never raises `int_out`.
- R3: A request is latched on a rising edge of its input. It is dropped if the input falls before the first acknowledge pulse, and `int_out` then falls.
- R4: Priority is fixed, with input 0 highest. `int_out` is high when some unmasked pending input ranks strictly above every in-service input.
- R5: The vector is word two bits 7..3 followed by the 3-bit index of the serviced input. It is driven (`d_oe`=1) only while `inta_n` is low during the second acknowledge pulse. During the first pulse `d_oe` stays low.
- R6: `cas_out` is always 000.
- R7: The first acknowledge pulse moves the winning bit from the pending set to the in-service set. `int_out` stays low until the pulse pair ends.
- R8: When word four bit 1 = 1, the serviced in-service bit clears at the end of the second acknowledge pulse.
- R9: Without automatic mode, the in-service bit stays set and blocks inputs of equal or lower priority. A write with `a0`=0, data bit 4 = 0, bit 3 = 0 and bit 5 = 1 clears the highest-priority in-service bit.
- R10: A read with `a0`=0 returns the pending set, including masked bits. A read with `a0`=1 returns the mask.
- R11: If no request qualifies at the first acknowledge pulse, the vector index is 7 and the in-service set is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Register address bit |
| d_in | input | 8 | Write data |
| d_out | output | 8 | Read data or vector |
| d_oe | output | 1 | Data bus drive enable |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to processor |
| inta_n | input | 1 | Acknowledge pulse, active low |
| cas_out | output | 3 | Cascade code |

## Verification
Random patterns of several simultaneous requests under a random mask and a random vector base show whether the resolver picks the lowest unmasked index. They also show whether the remaining requests re-raise the interrupt once automatic clearing has run. Directed sequences cover the rest:
- a request that drops before acknowledge, which must not be serviced;
- an acknowledge with nothing pending, which must give the default vector;
- nested service without automatic clearing, where lower inputs stay blocked until end-of-interrupt commands arrive;
- edges that arrive before setup is complete, which must be ignored.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int NUM_IN = 8;
  localparam int IDX_W  = $clog2(NUM_IN);
  localparam int BASE_W = 8 - IDX_W;

  typedef enum logic [2:0] {
    CFG_OFF, CFG_W2, CFG_W3, CFG_W4, CFG_RUN
  } cfg_st_t;

  typedef enum logic [1:0] {
    ACK_IDLE, ACK_ONE, ACK_GAP, ACK_TWO
  } ack_st_t;
endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg
  import pic8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              a0,
  input  logic [7:0]        wdata,
  output logic              armed,
  output logic [BASE_W-1:0] base,
  output logic              aeoi,
  output logic [NUM_IN-1:0] mask,
  output logic              init_clr,
  output logic              eoi
);
  cfg_st_t st_q;
  logic    single_q, need4_q;

  always_comb begin
    init_clr = wr_stb && !a0 && wdata[4];
    eoi      = wr_stb && !a0 && !wdata[4] && !wdata[3] && wdata[5] && (st_q == CFG_RUN);
    armed    = (st_q == CFG_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= CFG_OFF;
      base     <= '0;
      aeoi     <= 1'b0;
      mask     <= '0;
      single_q <= 1'b1;
      need4_q  <= 1'b0;
    end else if (init_clr) begin
      st_q     <= CFG_W2;
      single_q <= wdata[1];
      need4_q  <= wdata[0];
      mask     <= '0;
      aeoi     <= 1'b0;
    end else if (wr_stb && a0) begin
      case (st_q)
        CFG_W2: begin
          base <= wdata[7:IDX_W];
          if (!single_q)   st_q <= CFG_W3;
          else if (need4_q) st_q <= CFG_W4;
          else              st_q <= CFG_RUN;
        end
        CFG_W3:  st_q <= need4_q ? CFG_W4 : CFG_RUN;
        CFG_W4: begin
          aeoi <= wdata[1];
          st_q <= CFG_RUN;
        end
        CFG_RUN: mask <= wdata;
        default: ;
      endcase
    end
  end

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CFG_RUN && !(wr_stb && a0) && !init_clr) |=> $stable(mask));

  // R1
  seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CFG_W2 && wr_stb && a0 && !init_clr) |=> (st_q != CFG_W2));
endmodule

// File: rtl/pic8_irr.sv
module pic8_irr
  import pic8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              clr_all,
  input  logic [NUM_IN-1:0] irq,
  input  logic [NUM_IN-1:0] take,
  output logic [NUM_IN-1:0] irr
);
  logic [NUM_IN-1:0] irq_q, rise, irr_d;

  always_comb begin
    rise  = irq & ~irq_q;
    irr_d = ((irr | (rise & {NUM_IN{armed}})) & irq) & ~take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr   <= '0;
    end else begin
      irq_q <= irq;
      irr   <= clr_all ? '0 : irr_d;
    end
  end

  // R3
  irr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr & ~$past(irq)) == '0));
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio
  import pic8_pkg::*;
(
  input  logic [NUM_IN-1:0] pend,
  input  logic [NUM_IN-1:0] isr,
  output logic              req,
  output logic [IDX_W-1:0]  idx,
  output logic [NUM_IN-1:0] grant
);
  logic [NUM_IN-1:0] allowed, cand;
  logic              blocked, found;

  always_comb begin
    blocked = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (isr[i]) blocked = 1'b1;
      allowed[i] = !blocked;
    end
    cand  = pend & allowed;
    found = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (cand[i] && !found) begin
        found    = 1'b1;
        idx      = IDX_W'(i);
        grant[i] = 1'b1;
      end
    end
    req = found;
  end

  // R4
  grant_one_chk: assert final ($onehot0(grant));
endmodule

// File: rtl/pic8_ack.sv
module pic8_ack
  import pic8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inta_fall,
  input  logic              inta_rise,
  input  logic              inta_low,
  input  logic              clr_all,
  input  logic              aeoi,
  input  logic              eoi,
  input  logic              req,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BASE_W-1:0] base,
  output logic [NUM_IN-1:0] isr,
  output logic [NUM_IN-1:0] take,
  output logic              busy,
  output logic              vec_drive,
  output logic [7:0]        vector
);
  ack_st_t           st_q;
  logic [IDX_W-1:0]  sel_q;
  logic              spur_q;
  logic [NUM_IN-1:0] eoi_bit, isr_d;
  logic              first_ack;

  always_comb begin
    first_ack = (st_q == ACK_IDLE) && inta_fall;
    take      = (first_ack && req) ? (NUM_IN'(1) << idx) : '0;
    busy      = (st_q != ACK_IDLE);
    vec_drive = inta_low && (st_q == ACK_GAP || st_q == ACK_TWO);
    vector    = {base, sel_q};
    eoi_bit   = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (isr[i]) eoi_bit = NUM_IN'(1) << i;
    end
    isr_d = isr | take;
    if (st_q == ACK_TWO && inta_rise && aeoi && !spur_q)
      isr_d = isr_d & ~(NUM_IN'(1) << sel_q);
    if (eoi) isr_d = isr_d & ~eoi_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ACK_IDLE;
      sel_q  <= '0;
      spur_q <= 1'b0;
      isr    <= '0;
    end else if (clr_all) begin
      st_q   <= ACK_IDLE;
      spur_q <= 1'b0;
      isr    <= '0;
    end else begin
      isr <= isr_d;
      case (st_q)
        ACK_IDLE: if (inta_fall) begin
          st_q   <= ACK_ONE;
          sel_q  <= req ? idx : IDX_W'(NUM_IN - 1);
          spur_q <= !req;
        end
        ACK_ONE: if (inta_rise) st_q <= ACK_GAP;
        ACK_GAP: if (inta_fall) st_q <= ACK_TWO;
        ACK_TWO: if (inta_rise) st_q <= ACK_IDLE;
        default: st_q <= ACK_IDLE;
      endcase
    end
  end

  // R7
  take_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take != '0 && !clr_all) |=> ((isr & $past(take)) != '0));

  // R8
  aeoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ACK_TWO && inta_rise && aeoi && !spur_q && !clr_all)
      |=> ((isr & (NUM_IN'(1) << $past(sel_q))) == '0));

  // R11
  spur_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_ack && !req && !eoi && !clr_all) |=> $stable(isr));
endmodule

// File: rtl/pic8.sv
module pic8
  import pic8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       a0,
  input  logic [7:0] d_in,
  output logic [7:0] d_out,
  output logic       d_oe,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       inta_n,
  output logic [2:0] cas_out
);
  logic              wr_act, wr_act_q, wr_stb, rd_act;
  logic              inta_q, inta_fall, inta_rise;
  logic              armed, aeoi, init_clr, eoi;
  logic [BASE_W-1:0] base;
  logic [NUM_IN-1:0] mask, irr, isr, take, grant;
  logic              req, busy, vec_drive;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        vector;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      inta_q   <= 1'b1;
    end else begin
      wr_act_q <= wr_act;
      inta_q   <= inta_n;
    end
  end

  always_comb begin
    wr_act    = !cs_n && !wr_n;
    wr_stb    = wr_act && !wr_act_q;
    rd_act    = !cs_n && !rd_n;
    inta_fall = inta_q && !inta_n;
    inta_rise = !inta_q && inta_n;
  end

  pic8_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .a0(a0), .wdata(d_in),
    .armed(armed), .base(base), .aeoi(aeoi), .mask(mask),
    .init_clr(init_clr), .eoi(eoi)
  );

  pic8_irr u_irr (
    .clk(clk), .rst_n(rst_n), .armed(armed), .clr_all(init_clr),
    .irq(irq_in), .take(take), .irr(irr)
  );

  pic8_prio u_prio (
    .pend(irr & ~mask), .isr(isr), .req(req), .idx(idx), .grant(grant)
  );

  pic8_ack u_ack (
    .clk(clk), .rst_n(rst_n), .inta_fall(inta_fall), .inta_rise(inta_rise),
    .inta_low(!inta_n), .clr_all(init_clr), .aeoi(aeoi), .eoi(eoi),
    .req(req), .idx(idx), .base(base), .isr(isr), .take(take),
    .busy(busy), .vec_drive(vec_drive), .vector(vector)
  );

  always_comb begin
    int_out = armed && req && !busy;
    d_oe    = rd_act || vec_drive;
    if (vec_drive) d_out = vector;
    else           d_out = a0 ? mask : irr;
    cas_out = 3'b000;
  end

  // R5
  oe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (rd_act || !inta_n));

  // R2
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((grant & mask) == '0 && grant != '0));
endmodule

// File: tb/pic8_bench.sv
module pic8_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0, inta_n = 1'b1;
  logic [7:0] d_in = 8'h00, irq_in = 8'h00;
  logic [7:0] d_out;
  logic       d_oe, int_out;
  logic [2:0] cas_out;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic8 u_pic8 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .irq_in(irq_in),
    .int_out(int_out), .inta_n(inta_n), .cas_out(cas_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] lowest(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) lowest = 3'(i);
  endfunction

  function automatic logic [7:0] exp_vec(input logic [7:0] base, input logic [2:0] i);
    return {base[7:3], i};
  endfunction

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk); cs_n = 0; wr_n = 0; a0 = a; d_in = v;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); cs_n = 0; rd_n = 0; a0 = a;
    #1 v = d_out;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic setup(input logic [7:0] base, input logic [7:0] w4);
    wr(0, 8'h13); wr(1, base); wr(1, w4);
  endtask

  task automatic ack(output logic [7:0] v, output logic oe1, output logic oe2,
                     output logic [2:0] cas, output logic int_mid);
    @(negedge clk); inta_n = 0; #1 oe1 = d_oe;
    @(negedge clk); int_mid = int_out; inta_n = 1;
    @(negedge clk); inta_n = 0; #1 oe2 = d_oe; v = d_out; cas = cas_out;
    @(negedge clk); inta_n = 1;
    @(negedge clk);
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, base, msk, pat, en;
    logic       oe1, oe2, im;
    logic [2:0] cas;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset int", {7'd0, int_out}, 8'h00);
    chk("R5 reset oe", {7'd0, d_oe}, 8'h00);
    chk("R6 reset cas", {5'd0, cas_out}, 8'h00);

    // R1: edges before setup are ignored
    set_irq(8'h01);
    chk("R1 unarmed int", {7'd0, int_out}, 8'h00);
    rd(0, v); chk("R1 unarmed irr", v, 8'h00);
    set_irq(8'h00);

    setup(8'h00, 8'h0F);
    wr(1, 8'hFE);
    set_irq(8'h01);
    chk("R4 int raised", {7'd0, int_out}, 8'h01);
    rd(0, v); chk("R10 read irr", v, 8'h01);
    rd(1, v); chk("R10 read mask", v, 8'hFE);
    ack(v, oe1, oe2, cas, im);
    chk("R5 vector", v, 8'h00);
    chk("R5 oe first", {7'd0, oe1}, 8'h00);
    chk("R5 oe second", {7'd0, oe2}, 8'h01);
    chk("R6 cas", {5'd0, cas}, 8'h00);
    chk("R7 int mid", {7'd0, im}, 8'h00);
    chk("R7 int after", {7'd0, int_out}, 8'h00);
    set_irq(8'h00);

    // R2 masked input
    set_irq(8'h02);
    chk("R2 masked int", {7'd0, int_out}, 8'h00);
    rd(0, v); chk("R10 masked irr", v, 8'h02);
    set_irq(8'h00);
    rd(0, v); chk("R3 drop clears irr", v, 8'h00);

    // R3 dropped request
    wr(1, 8'h00);
    set_irq(8'h08);
    chk("R3 int up", {7'd0, int_out}, 8'h01);
    set_irq(8'h00);
    chk("R3 int dropped", {7'd0, int_out}, 8'h00);

    // R11 spurious
    set_irq(8'h08); set_irq(8'h00);
    ack(v, oe1, oe2, cas, im);
    chk("R11 default vector", v, 8'h07);
    set_irq(8'h80);
    chk("R11 isr untouched", {7'd0, int_out}, 8'h01);
    ack(v, oe1, oe2, cas, im);
    chk("R4 lowest input vector", v, 8'h07);
    set_irq(8'h00);

    // R9 nesting without automatic clear
    setup(8'h48, 8'h0D);
    wr(1, 8'h00);
    set_irq(8'h10);
    ack(v, oe1, oe2, cas, im);
    chk("R5 base vector", v, 8'h4C);
    set_irq(8'h30);
    chk("R9 lower blocked", {7'd0, int_out}, 8'h00);
    set_irq(8'h34);
    chk("R4 higher nests", {7'd0, int_out}, 8'h01);
    ack(v, oe1, oe2, cas, im);
    chk("R4 nested vector", v, 8'h4A);
    wr(0, 8'h20);
    @(negedge clk);
    chk("R9 still blocked", {7'd0, int_out}, 8'h00);
    wr(0, 8'h20);
    @(negedge clk);
    chk("R9 eoi releases", {7'd0, int_out}, 8'h01);
    ack(v, oe1, oe2, cas, im);
    chk("R9 released vector", v, 8'h4D);
    wr(0, 8'h20);
    set_irq(8'h00);

    // R1 re-setup clears mask
    wr(1, 8'hAA);
    setup(8'h00, 8'h0F);
    rd(1, v); chk("R1 mask cleared", v, 8'h00);

    for (int it = 0; it < 24; it++) begin
      base = 8'($urandom);
      msk  = 8'($urandom);
      pat  = 8'($urandom) | 8'h01 << (it % 8);
      setup(base, 8'h0F);
      wr(1, msk);
      set_irq(pat);
      en = pat & ~msk;
      chk("R2 random int", {7'd0, int_out}, {7'd0, en != 0});
      if (en != 0) begin
        ack(v, oe1, oe2, cas, im);
        chk("R4 random vector", v, exp_vec(base, lowest(en)));
        en = en & ~(8'h01 << lowest(en));
        chk("R8 auto clear", {7'd0, int_out}, {7'd0, en != 0});
      end
      set_irq(8'h00);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule